// File: doc/BRIEF.md
# Keystream Block Core

This core turns a 256-bit key, a 96-bit nonce and a 32-bit block counter into one 512-bit keystream block of the well-known 20-round add-rotate-xor stream cipher. It XORs that block with a 512-bit data word to give the encrypted or decrypted result. Encryption and decryption are the same operation.

Two banks of sixteen 32-bit words hold the state. The seed bank holds the state the block starts from. The working bank is scrambled by four quarter-round units, one full column or diagonal round per clock. A start strobe (`init_i`) loads a fresh key, nonce and counter. A continue strobe (`next_i`) reuses the stored key and nonce with the counter advanced by one, so a message is handled as one `init_i` followed by any number of `next_i` pulses. The data word is captured in the cycle a strobe is accepted. The result stays on `result_o`, qualified by `valid_o`, until the next accepted strobe.

The result is a single 512-bit word on plain level signals, with no handshake at the port. A consumer that cannot take a result simply holds off its next strobe: `valid_o` and `result_o` stay put until then, and this is the only back-pressure the core has.

Top module: `sc_block_core`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `busy_o` and `valid_o` are 0 and `result_o` is all zeros until a strobe is accepted.
- R2: On an accepted `init_i`, the seed state is laid out as follows. Words 0..3 are the constants 0x61707865, 0x3320646e, 0x79622d32 and 0x6b206574. Word 4+k is `key_i[32k+31:32k]`. Word 12 is `ctr_i`. Word 13+n is `nonce_i[32n+31:32n]`. Byte j of the key and of the nonce sits at bits [8j+7:8j], so each word is read little-endian.
- R3: The working state goes through 20 rounds that alternate column and diagonal, starting with a column round. A column round acts on {0,4,8,12}, {1,5,9,13}, {2,6,10,14} and {3,7,11,15}. A diagonal round acts on {0,5,10,15}, {1,6,11,12}, {2,7,8,13} and {3,4,9,14}. The quarter round on (a,b,c,d) is: a+=b; d^=a; d<<<=16; c+=d; b^=c; b<<<=12; a+=b; d^=a; d<<<=8; c+=d; b^=c; b<<<=7. Every addition is modulo 2^32.
- R4: Result word i, `result_o[32i+31:32i]`, equals (working word i + seed word i) XOR `data_i[32i+31:32i]`. The data value used is the one captured when the strobe was accepted.
- R5: An accepted `next_i` (with `init_i` low) produces the block for the stored key and nonce with the counter one above the previous block's counter. `key_i`, `nonce_i` and `ctr_i` are ignored in that case.
- R6: The block counter wraps modulo 2^32: after a block with counter 0xFFFFFFFF, `next_i` gives the block with counter 0.
- R7: Latency is fixed. Count the rising edge that accepts a strobe as edge 1. `valid_o` becomes 1 right after edge 22, and `busy_o` is 1 in between. `busy_o` and `valid_o` are never both 1.
- R8: `init_i` and `next_i` have no effect while `busy_o` is 1. The running block finishes on schedule with its original inputs.
- R9: `valid_o` and `result_o` hold steady until the next accepted strobe. The cycle after a strobe is accepted, `valid_o` is 0 and `busy_o` is 1.
- R10: If `init_i` and `next_i` are both high when accepted, `init_i` wins and a fresh state is loaded from the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Start a message with a new key, nonce and counter |
| next_i | input | 1 | Produce the following block with the counter plus one |
| key_i | input | 256 | Key, byte j at bits [8j+7:8j] |
| nonce_i | input | 96 | Nonce, byte j at bits [8j+7:8j] |
| ctr_i | input | 32 | Initial block counter, used on `init_i` |
| data_i | input | 512 | Data word to combine with the keystream, captured at the strobe |
| busy_o | output | 1 | A block is being computed |
| valid_o | output | 1 | `result_o` holds a finished block |
| result_o | output | 512 | Keystream XOR data, word i at bits [32i+31:32i] |

## Verification
The hardest cases to reach from the ports are the counter wrap and strobes that land mid-computation. Counter overflow normally needs 2^32 blocks. The bench gets there in two blocks by loading 0xFFFFFFFF through `init_i` and then pulsing `next_i`. To test that strobes are ignored while busy, the bench pulses `init_i`, with a different key and counter, several cycles into a running block. It then checks both the unchanged latency and the result of the original block. `next_i` blocks are driven with deliberately wrong values on the key, nonce and counter ports, which shows the stored state is used.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned N_WORDS     = 16;
  localparam int unsigned N_LANES     = 4;
  localparam int unsigned QR_ARGS     = 4;
  localparam int unsigned N_CONST     = 4;
  localparam int unsigned KEY_WORDS   = 8;
  localparam int unsigned NONCE_WORDS = 3;
  localparam int unsigned KEY_BASE    = N_CONST;
  localparam int unsigned CTR_IDX     = KEY_BASE + KEY_WORDS;
  localparam int unsigned NONCE_BASE  = CTR_IDX + 1;
  localparam int unsigned IDX_W       = $clog2(N_WORDS);
  localparam int unsigned STATE_W     = N_WORDS * WORD_W;

  typedef logic [WORD_W-1:0]  word_t;
  typedef word_t [N_WORDS-1:0] state_t;
  typedef logic [IDX_W-1:0]   idx_t;

  // Fixed words at the head of every seed state.
  function automatic word_t sigma_word(input int i);
    case (i)
      0:       return 32'h61707865;
      1:       return 32'h3320646e;
      2:       return 32'h79622d32;
      default: return 32'h6b206574;
    endcase
  endfunction

  // State slot of argument pos of quarter-round lane in a column or diagonal round.
  function automatic idx_t slot(input int lane, input int pos, input logic diag);
    int col;
    col = diag ? ((lane + pos) % N_LANES) : lane;
    return idx_t'(pos * N_LANES + col);
  endfunction

  // Rotate left by a constant amount: only wires when n is fixed.
  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/sc_qround.sv
module sc_qround
  import sc_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;
  word_t a2, b2, c2, d2;

  // First half: rotations by 16 and 12.
  assign a1 = a_i + b_i;
  assign d1 = rotl(d_i ^ a1, 16);
  assign c1 = c_i + d1;
  assign b1 = rotl(b_i ^ c1, 12);

  // Second half: rotations by 8 and 7.
  assign a2 = a1 + b1;
  assign d2 = rotl(d1 ^ a2, 8);
  assign c2 = c1 + d2;
  assign b2 = rotl(b1 ^ c2, 7);

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;
endmodule

// File: rtl/sc_round_mix.sv
module sc_round_mix
  import sc_pkg::*;
(
  input  state_t st_i,
  input  logic   diag_i,
  output state_t st_o
);
  word_t qin  [N_LANES][QR_ARGS];
  word_t qout [N_LANES][QR_ARGS];

  // Route state words to the lanes for this round's pattern.
  always_comb begin
    for (int l = 0; l < N_LANES; l++) begin
      for (int p = 0; p < QR_ARGS; p++) begin
        qin[l][p] = st_i[slot(l, p, diag_i)];
      end
    end
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    sc_qround u_qr (
      .a_i(qin[g][0]), .b_i(qin[g][1]), .c_i(qin[g][2]), .d_i(qin[g][3]),
      .a_o(qout[g][0]), .b_o(qout[g][1]), .c_o(qout[g][2]), .d_o(qout[g][3])
    );
  end

  // Put lane results back in the slots they came from.
  always_comb begin
    st_o = st_i;
    for (int l = 0; l < N_LANES; l++) begin
      for (int p = 0; p < QR_ARGS; p++) begin
        st_o[slot(l, p, diag_i)] = qout[l][p];
      end
    end
  end
endmodule

// File: rtl/sc_round_fsm.sv
module sc_round_fsm #(
  parameter int unsigned ROUNDS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic next_i,
  output logic load_o,
  output logic fresh_o,
  output logic step_o,
  output logic diag_o,
  output logic fin_o,
  output logic busy_o
);
  localparam int unsigned RND_W = (ROUNDS > 2) ? $clog2(ROUNDS) : 1;
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} phase_e;

  phase_e           phase_q;
  logic [RND_W-1:0] rnd_q;

  assign busy_o  = (phase_q != S_IDLE);
  assign load_o  = !busy_o && (init_i || next_i);
  assign fresh_o = init_i;
  assign step_o  = (phase_q == S_RUN);
  assign diag_o  = rnd_q[0];
  assign fin_o   = (phase_q == S_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= S_IDLE;
      rnd_q   <= '0;
    end else begin
      case (phase_q)
        S_IDLE: if (load_o) begin
          phase_q <= S_RUN;
          rnd_q   <= '0;
        end
        S_RUN: begin
          if (rnd_q == LAST_RND) phase_q <= S_FIN;
          else                   rnd_q   <= rnd_q + 1'b1;
        end
        default: phase_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_block_core.sv
module sc_block_core
  import sc_pkg::*;
#(
  parameter int unsigned ROUNDS = 20
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          init_i,
  input  logic                          next_i,
  input  logic [KEY_WORDS*WORD_W-1:0]   key_i,
  input  logic [NONCE_WORDS*WORD_W-1:0] nonce_i,
  input  logic [WORD_W-1:0]             ctr_i,
  input  logic [STATE_W-1:0]            data_i,
  output logic                          busy_o,
  output logic                          valid_o,
  output logic [STATE_W-1:0]            result_o
);
  state_t seed_q, work_q, data_q, result_q;
  state_t fresh, mixed, stream;
  logic   valid_q;
  logic   load, fresh_sel, step, diag, fin;

  sc_round_fsm #(.ROUNDS(ROUNDS)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .next_i(next_i),
    .load_o(load), .fresh_o(fresh_sel), .step_o(step), .diag_o(diag),
    .fin_o(fin), .busy_o(busy_o)
  );

  sc_round_mix u_mix (.st_i(work_q), .diag_i(diag), .st_o(mixed));

  // Seed state assembled straight from the ports.
  always_comb begin
    for (int i = 0; i < N_CONST; i++)     fresh[i] = sigma_word(i);
    for (int k = 0; k < KEY_WORDS; k++)   fresh[KEY_BASE + k] = key_i[k*WORD_W +: WORD_W];
    fresh[CTR_IDX] = ctr_i;
    for (int n = 0; n < NONCE_WORDS; n++) fresh[NONCE_BASE + n] = nonce_i[n*WORD_W +: WORD_W];
  end

  // Feed-forward add and data combine, one adder per word.
  for (genvar w = 0; w < N_WORDS; w++) begin : g_out
    assign stream[w] = (work_q[w] + seed_q[w]) ^ data_q[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q   <= '0;
      work_q   <= '0;
      data_q   <= '0;
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      if (load) begin
        valid_q <= 1'b0;
        data_q  <= data_i;
        if (fresh_sel) begin
          seed_q <= fresh;
          work_q <= fresh;
        end else begin
          work_q <= seed_q;
        end
      end else if (step) begin
        work_q <= mixed;
      end else if (fin) begin
        result_q         <= stream;
        valid_q          <= 1'b1;
        seed_q[CTR_IDX]  <= seed_q[CTR_IDX] + 1'b1;
      end
    end
  end

  assign valid_o  = valid_q;
  assign result_o = result_q;
endmodule

// File: rtl/sc_block_core_chk.sv
module sc_block_core_chk #(
  parameter int unsigned ROUNDS = 20
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         init_i,
  input logic         next_i,
  input logic         busy_o,
  input logic         valid_o,
  input logic [511:0] result_o
);
  localparam logic [7:0] LAT = 8'(ROUNDS + 1);

  logic       acc;
  logic [7:0] busy_run_q;

  assign acc = (init_i || next_i) && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              busy_run_q <= '0;
    else if (!busy_o)         busy_run_q <= '0;
    else if (busy_run_q != 8'hFF) busy_run_q <= busy_run_q + 1'b1;
  end

  a_r7_busy_valid_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && valid_o));

  // R7 and R8: a strobe during a run must not stretch it.
  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (busy_run_q == LAT));

  a_r9_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !acc) |=> valid_o);

  a_r9_result_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !acc) |=> $stable(result_o));

  a_r9_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (busy_o && !valid_o));
endmodule

bind sc_block_core sc_block_core_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .next_i(next_i),
  .busy_o(busy_o), .valid_o(valid_o), .result_o(result_o)
);

// File: tb/sc_block_core_tb.sv
`timescale 1ns/1ps
module sc_block_core_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         init_i = 1'b0;
  logic         next_i = 1'b0;
  logic [255:0] key_i = '0;
  logic [95:0]  nonce_i = '0;
  logic [31:0]  ctr_i = '0;
  logic [511:0] data_i = '0;
  logic         busy_o, valid_o;
  logic [511:0] result_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  sc_block_core u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .next_i(next_i),
    .key_i(key_i), .nonce_i(nonce_i), .ctr_i(ctr_i), .data_i(data_i),
    .busy_o(busy_o), .valid_o(valid_o), .result_o(result_o)
  );

  typedef struct packed {
    logic         use_next;
    logic [255:0] key;
    logic [95:0]  nonce;
    logic [31:0]  ctr;
    logic [511:0] data;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{use_next: 1'b0, key: {4{64'h0123456789abcdef}}, nonce: 96'hcafef00d_12345678_9abcdef0,
      ctr: 32'd7, data: {16{32'hffffffff}}},
    '{use_next: 1'b1, key: {8{32'hdeadbeef}}, nonce: 96'h5555, ctr: 32'd999,
      data: {8{64'h00ff00ff_a5a5a5a5}}},
    '{use_next: 1'b1, key: '0, nonce: 96'h1, ctr: '0, data: '0},
    '{use_next: 1'b0, key: {8{32'h13579bdf}}, nonce: 96'h0000004a_00000009_0badf00d,
      ctr: 32'h80000000, data: {16{32'h5a5a0f0f}}}
  };

  localparam int QIDX [8][4] = '{
    '{0, 4, 8, 12}, '{1, 5, 9, 13}, '{2, 6, 10, 14}, '{3, 7, 11, 15},
    '{0, 5, 10, 15}, '{1, 6, 11, 12}, '{2, 7, 8, 13}, '{3, 4, 9, 14}
  };

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // Independent model built from R2, R3 and R4.
  function automatic logic [511:0] model(input logic [255:0] k, input logic [95:0] n,
                                         input logic [31:0] c, input logic [511:0] d);
    logic [31:0] s [16];
    logic [31:0] w [16];
    logic [31:0] a, b, cc, dd;
    logic [511:0] r;
    s[0] = 32'h61707865; s[1] = 32'h3320646e; s[2] = 32'h79622d32; s[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
    s[12] = c;
    for (int i = 0; i < 3; i++) s[13+i] = n[32*i +: 32];
    for (int i = 0; i < 16; i++) w[i] = s[i];
    for (int dr = 0; dr < 10; dr++) begin
      for (int q = 0; q < 8; q++) begin
        a = w[QIDX[q][0]]; b = w[QIDX[q][1]]; cc = w[QIDX[q][2]]; dd = w[QIDX[q][3]];
        a = a + b;  dd = rl(dd ^ a, 16);
        cc = cc + dd; b = rl(b ^ cc, 12);
        a = a + b;  dd = rl(dd ^ a, 8);
        cc = cc + dd; b = rl(b ^ cc, 7);
        w[QIDX[q][0]] = a; w[QIDX[q][1]] = b; w[QIDX[q][2]] = cc; w[QIDX[q][3]] = dd;
      end
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = (w[i] + s[i]) ^ d[32*i +: 32];
    return r;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Strobe once, then count edges until valid is seen between edges.
  task automatic run_block(input logic i_s, input logic n_s, input logic [255:0] k,
                           input logic [95:0] n, input logic [31:0] c,
                           input logic [511:0] d, output int lat);
    @(negedge clk_i);
    init_i = i_s; next_i = n_s; key_i = k; nonce_i = n; ctr_i = c; data_i = d;
    lat = 0;
    do begin
      @(posedge clk_i);
      lat++;
      @(negedge clk_i);
      init_i = 1'b0; next_i = 1'b0;
    end while (!valid_o && lat < 100);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  initial begin
    logic [255:0] ck;
    logic [95:0]  cn;
    logic [31:0]  cc;
    logic [511:0] exp;
    logic [511:0] held;
    int lat;

    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", {511'd0, valid_o}, '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 busy after reset", {511'd0, busy_o}, '0);
    check("R1 valid after reset", {511'd0, valid_o}, '0);
    check("R1 result after reset", result_o, '0);

    // R2/R3: published block-function vector, zero data.
    for (int j = 0; j < 32; j++) ck[8*j +: 8] = 8'(j);
    cn = '0; cn[31:24] = 8'h09; cn[63:56] = 8'h4a;
    exp = {32'h4e3c50a2, 32'he883d0cb, 32'hb94e16de, 32'hd19c12b5,
           32'ha2028bd9, 32'h05d7c214, 32'h09aa9f07, 32'h466482d2,
           32'h4e6cd4c3, 32'h9aaa2204, 32'h0368c033, 32'hc7f4d1c7,
           32'hc47120a3, 32'h1fdd0f50, 32'h15593bd1, 32'he4e7f110};
    run_block(1'b1, 1'b0, ck, cn, 32'd1, '0, lat);
    check("R2 R3 known vector", result_o, exp);
    check("R7 latency", 512'(lat), 512'd22);

    // Table walk: R4 data combine, R5 continue with wrong port values.
    ck = '0; cn = '0; cc = '0;
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].use_next) begin
        cc = cc + 1;
        run_block(1'b0, 1'b1, VECS[v].key, VECS[v].nonce, VECS[v].ctr, VECS[v].data, lat);
        check("R5 next block", result_o, model(ck, cn, cc, VECS[v].data));
      end else begin
        ck = VECS[v].key; cn = VECS[v].nonce; cc = VECS[v].ctr;
        run_block(1'b1, 1'b0, ck, cn, cc, VECS[v].data, lat);
        check("R4 init block", result_o, model(ck, cn, cc, VECS[v].data));
      end
      check("R7 table latency", 512'(lat), 512'd22);
    end

    // R6: counter wrap.
    ck = {8{32'h2468ace0}}; cn = 96'h77_00000001;
    run_block(1'b1, 1'b0, ck, cn, 32'hffffffff, '0, lat);
    check("R6 top counter", result_o, model(ck, cn, 32'hffffffff, '0));
    run_block(1'b0, 1'b1, '1, '1, 32'h12345678, '0, lat);
    check("R6 wrapped counter", result_o, model(ck, cn, 32'h0, '0));

    // R8: strobes during a run are ignored.
    @(negedge clk_i);
    init_i = 1'b1; key_i = {8{32'h0f0f0f0f}}; nonce_i = 96'h3; ctr_i = 32'd3;
    data_i = {16{32'h01234567}};
    lat = 0;
    do begin
      @(posedge clk_i);
      lat++;
      @(negedge clk_i);
      init_i = (lat == 5) || (lat == 9);
      next_i = (lat == 12);
      if (lat == 1) begin
        key_i = {8{32'hffff0000}}; ctr_i = 32'd77; data_i = '0;
      end
    end while (!valid_o && lat < 100);
    init_i = 1'b0; next_i = 1'b0;
    check("R8 result unchanged", result_o, model({8{32'h0f0f0f0f}}, 96'h3, 32'd3, {16{32'h01234567}}));
    check("R8 latency unchanged", 512'(lat), 512'd22);

    // R9: hold, then clear on a new strobe.
    held = result_o;
    repeat (10) @(negedge clk_i);
    check("R9 valid holds", {511'd0, valid_o}, 512'd1);
    check("R9 result holds", result_o, held);
    init_i = 1'b1; key_i = {8{32'h99887766}}; nonce_i = 96'h8; ctr_i = 32'd5; data_i = '0;
    @(posedge clk_i);
    @(negedge clk_i);
    init_i = 1'b0;
    check("R9 valid clears, busy set", {510'd0, busy_o, valid_o}, 512'd2);
    while (!valid_o) @(negedge clk_i);

    // R10: both strobes, init wins.
    run_block(1'b1, 1'b1, {8{32'h10203040}}, 96'h44, 32'd500, '0, lat);
    check("R10 init priority", result_o, model({8{32'h10203040}}, 96'h44, 32'd500, '0));

    summary();
  end
endmodule